// File: doc/BRIEF.md
# Clock-Loss Supervisor and Source Selector

This block watches two synchronous failure indications, one for the reference clock and one for the PLL feedback path, and decides where the system clock comes from. It picks one of four sources: the PLL output, the PLL reference, the PLL running self-clocked, or a halted static state. Every failure-driven change of source holds until the next reset, even after the failed clock comes back. When both clocks fail, the reference failure wins. Alongside the source code, the block gates the frequency-modulation enable and the reduced-frequency divider. It also raises a reset request, an interrupt request and status flags, and it keeps a reset-cause bit that outlives the reset it caused.

Enable bits, the bypass flag, the divider value and a write-one-to-clear strobe arrive as plain register outputs. The block does not build the glitch-free clock mux. It only produces the 2-bit select code that drives such a mux.

Top module: `clkloss_sup`

## Requirements
- R1: After `rst_n` is released, `rst_hold` stays 1 until a cycle in which `ref_fail`=0 and, outside bypass, `pll_lock`=1. It then drops to 0 at the next clock edge and stays 0 until the next reset. While `rst_hold`=1, failure inputs cause no source change.
- R2: `src_sel` encoding is 00 = PLL output, 01 = PLL reference, 10 = self-clocked, 11 = halted. After reset it reads 00, or 01 when `cfg_bypass`=1.
- R3: With `cfg_loc_en`=1 and no bypass, a `pll_fail` sampled while the source is 00 moves the source to 01 at the next edge.
- R4: With `cfg_loc_en`=1 and no bypass, a `ref_fail` sampled while the source is 00 or 01 moves the source to 10 if `scm_ok`=1, or to 11 otherwise. This holds even when `pll_fail` is set in the same cycle.
- R5: A failure-driven source change holds until `rst_n` is asserted, whatever the failure inputs do afterwards.
- R6: With `cfg_bypass`=1, `src_sel` reads 01 and the failure inputs change no source, flag or request. With `cfg_loc_en`=0, failure inputs are likewise ignored.
- R7: `rst_req` is a one-cycle pulse, asserted in the cycle after a failure is recognised, only if `cfg_locre`=1.
- R8: `loc_flag` sets on a recognised failure and clears on a `flag_clr` pulse. `loc_sticky` sets on a recognised failure and clears only on reset. Both read 0 after reset.
- R9: `irq` equals `loc_flag` AND `cfg_locirq` AND `cfg_loc_en` AND NOT `cfg_bypass`.
- R10: `rst_by_loc` sets one edge after `rst_req`, is cleared only by `por_n`, and is unaffected by `rst_n`.
- R11: `mod_gate` equals `cfg_mod_en` only while `src_sel`=00, and is 0 otherwise. This includes self-clocked mode.
- R12: `rfd_eff` reads 0 while `src_sel`=10 and reads `cfg_rfd` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| por_n | input | 1 | Power-on reset, active low; clears only `rst_by_loc` |
| cfg_bypass | input | 1 | Bypass mode: PLL not in the clock path |
| cfg_loc_en | input | 1 | Enable loss-of-clock source switching |
| cfg_locre | input | 1 | Enable reset request on loss of clock |
| cfg_locirq | input | 1 | Enable interrupt on loss of clock |
| cfg_mod_en | input | 1 | Programmed modulation enable |
| cfg_rfd | input | RFD_W | Programmed reduced-frequency divider |
| flag_clr | input | 1 | Write-one-to-clear pulse for `loc_flag` |
| ref_fail | input | 1 | Reference clock failure level |
| pll_fail | input | 1 | PLL feedback failure level |
| scm_ok | input | 1 | Self-clocked operation is possible |
| pll_lock | input | 1 | PLL lock indication |
| src_sel | output | 2 | Selected clock source code |
| rfd_eff | output | RFD_W | Effective divider value |
| mod_gate | output | 1 | Gated modulation enable |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Interrupt request level |
| loc_flag | output | 1 | Clearable loss-of-clock flag |
| loc_sticky | output | 1 | Loss-of-clock status, cleared by reset only |
| rst_by_loc | output | 1 | Reset-cause bit surviving `rst_n` |
| rst_hold | output | 1 | Hold the system in reset |

## Verification
The assertions assume that the failure, lock and `scm_ok` inputs are already synchronous to `clk`. They also assume that the configuration bits change only while no failure is being recognised, because `irq` and `mod_gate` are combinational on them. The bench changes every input half a cycle away from the active edge. It sets the configuration while `rst_n` is low and keeps it fixed through each scenario. It then sweeps all 128 combinations of bypass, the three enables, both failures and `scm_ok`, followed by a second-stage reference failure. `por_n` is pulsed only at scenario start, so the reset-cause bit can be checked across a `rst_n` pulse.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;
  typedef enum logic [1:0] {
    SRC_PLL  = 2'b00,
    SRC_REF  = 2'b01,
    SRC_SCM  = 2'b10,
    SRC_HALT = 2'b11
  } src_e;

  // next source given current source and failure levels; reference failure first
  function automatic src_e next_src(src_e cur, logic ref_bad, logic pll_bad, logic scm_good);
    src_e n;
    n = cur;
    if ((cur == SRC_PLL || cur == SRC_REF) && ref_bad)
      n = scm_good ? SRC_SCM : SRC_HALT;
    else if (cur == SRC_PLL && pll_bad)
      n = SRC_REF;
    return n;
  endfunction

  // source code seen at the mux
  function automatic logic [1:0] out_sel(src_e cur, logic byp);
    return byp ? 2'(SRC_REF) : 2'(cur);
  endfunction
endpackage

// File: rtl/clkloss_fsm.sv
module clkloss_fsm
  import clkloss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic loc_en,
  input  logic ref_fail,
  input  logic pll_fail,
  input  logic scm_ok,
  input  logic pll_lock,
  output src_e state,
  output logic loc_hit,
  output logic rst_hold
);
  logic released;
  logic run;
  src_e nxt;

  assign run     = released && loc_en && !bypass;
  assign nxt     = run ? next_src(state, ref_fail, pll_fail, scm_ok) : state;
  assign loc_hit = (nxt != state);
  assign rst_hold = !released;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      released <= 1'b0;
      state    <= SRC_PLL;
    end else begin
      if (!ref_fail && (bypass || pll_lock))
        released <= 1'b1;
      state <= nxt;
    end
  end

  // R5
  sticky_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SRC_PLL) |=> (state != SRC_PLL));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SRC_HALT) |=> (state == SRC_HALT));

  // R4
  ref_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ref_fail && (state == SRC_PLL || state == SRC_REF))
      |=> (state == SRC_SCM || state == SRC_HALT));

  // R6
  bypass_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> $stable(state));

  // R1
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hold |=> (state == SRC_PLL));
endmodule

// File: rtl/clkloss_req.sv
module clkloss_req (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  logic loc_hit,
  input  logic locre,
  input  logic locirq,
  input  logic loc_en,
  input  logic bypass,
  input  logic flag_clr,
  output logic rst_req,
  output logic loc_flag,
  output logic loc_sticky,
  output logic irq,
  output logic rst_by_loc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req    <= 1'b0;
      loc_flag   <= 1'b0;
      loc_sticky <= 1'b0;
    end else begin
      rst_req <= loc_hit && locre;
      if (loc_hit)
        loc_flag <= 1'b1;
      else if (flag_clr)
        loc_flag <= 1'b0;
      if (loc_hit)
        loc_sticky <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      rst_by_loc <= 1'b0;
    else if (rst_req)
      rst_by_loc <= 1'b1;
  end

  assign irq = loc_flag && locirq && loc_en && !bypass;

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_sticky |=> loc_sticky);

  // R10
  cause_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> rst_by_loc);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> loc_flag);
endmodule

// File: rtl/clkloss_sup.sv
module clkloss_sup
  import clkloss_pkg::*;
#(
  parameter int RFD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             cfg_bypass,
  input  logic             cfg_loc_en,
  input  logic             cfg_locre,
  input  logic             cfg_locirq,
  input  logic             cfg_mod_en,
  input  logic [RFD_W-1:0] cfg_rfd,
  input  logic             flag_clr,
  input  logic             ref_fail,
  input  logic             pll_fail,
  input  logic             scm_ok,
  input  logic             pll_lock,
  output logic [1:0]       src_sel,
  output logic [RFD_W-1:0] rfd_eff,
  output logic             mod_gate,
  output logic             rst_req,
  output logic             irq,
  output logic             loc_flag,
  output logic             loc_sticky,
  output logic             rst_by_loc,
  output logic             rst_hold
);
  localparam logic [RFD_W-1:0] RFD_SCM = '0;

  src_e state;
  logic loc_hit;

  clkloss_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass   (cfg_bypass),
    .loc_en   (cfg_loc_en),
    .ref_fail (ref_fail),
    .pll_fail (pll_fail),
    .scm_ok   (scm_ok),
    .pll_lock (pll_lock),
    .state    (state),
    .loc_hit  (loc_hit),
    .rst_hold (rst_hold)
  );

  clkloss_req u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .loc_hit    (loc_hit),
    .locre      (cfg_locre),
    .locirq     (cfg_locirq),
    .loc_en     (cfg_loc_en),
    .bypass     (cfg_bypass),
    .flag_clr   (flag_clr),
    .rst_req    (rst_req),
    .loc_flag   (loc_flag),
    .loc_sticky (loc_sticky),
    .irq        (irq),
    .rst_by_loc (rst_by_loc)
  );

  assign src_sel  = out_sel(state, cfg_bypass);
  assign mod_gate = cfg_mod_en && (src_sel == 2'(SRC_PLL));
  assign rfd_eff  = (src_sel == 2'(SRC_SCM)) ? RFD_SCM : cfg_rfd;

  // R11
  scm_no_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SRC_SCM) |-> !mod_gate);

  // R7
  req_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (state != SRC_PLL));
endmodule

// File: tb/clkloss_sup_tb.sv
module clkloss_sup_tb;
  localparam int PERIOD = 10;
  localparam int RFD_W = 3;

  logic clk = 1'b0;
  logic rst_n, por_n, cfg_bypass, cfg_loc_en, cfg_locre, cfg_locirq, cfg_mod_en;
  logic [RFD_W-1:0] cfg_rfd;
  logic flag_clr, ref_fail, pll_fail, scm_ok, pll_lock;
  logic [1:0] src_sel;
  logic [RFD_W-1:0] rfd_eff;
  logic mod_gate, rst_req, irq, loc_flag, loc_sticky, rst_by_loc, rst_hold;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  clkloss_sup #(.RFD_W(RFD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cfg_bypass(cfg_bypass),
    .cfg_loc_en(cfg_loc_en), .cfg_locre(cfg_locre), .cfg_locirq(cfg_locirq),
    .cfg_mod_en(cfg_mod_en), .cfg_rfd(cfg_rfd), .flag_clr(flag_clr),
    .ref_fail(ref_fail), .pll_fail(pll_fail), .scm_ok(scm_ok), .pll_lock(pll_lock),
    .src_sel(src_sel), .rfd_eff(rfd_eff), .mod_gate(mod_gate), .rst_req(rst_req),
    .irq(irq), .loc_flag(loc_flag), .loc_sticky(loc_sticky),
    .rst_by_loc(rst_by_loc), .rst_hold(rst_hold)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected source after one sampled cycle of failure inputs
  function automatic int model_src(int cur, bit byp, bit en, bit rf, bit pf, bit so);
    if (byp || !en) return cur;
    if ((cur == 0 || cur == 1) && rf) return so ? 2 : 3;
    if (cur == 0 && pf) return 1;
    return cur;
  endfunction

  task automatic check_view(string sc, int st, bit byp, bit me);
    int sel;
    sel = byp ? 1 : st;
    check({"R2 src_sel ", sc}, src_sel, sel);
    check({"R11 mod_gate ", sc}, mod_gate, (me && sel == 0) ? 1 : 0);
    check({"R12 rfd_eff ", sc}, rfd_eff, (sel == 2) ? 0 : 5);
  endtask

  initial begin
    rst_n = 0; por_n = 0; cfg_bypass = 0; cfg_loc_en = 0; cfg_locre = 0;
    cfg_locirq = 0; cfg_mod_en = 1; cfg_rfd = 3'd5; flag_clr = 0;
    ref_fail = 0; pll_fail = 0; scm_ok = 1; pll_lock = 0;
    @(negedge clk); @(negedge clk);
    check("R2 reset src_sel", src_sel, 0);
    check("R8 reset loc_flag", loc_flag, 0);
    check("R10 reset rst_by_loc", rst_by_loc, 0);
    check("R1 reset rst_hold", rst_hold, 1);

    // R1: hold while no lock, failures ignored meanwhile
    por_n = 1; rst_n = 1; cfg_loc_en = 1; cfg_locre = 1;
    step();
    check("R1 hold without lock", rst_hold, 1);
    ref_fail = 1; pll_lock = 1;
    step();
    check("R1 hold with ref missing", rst_hold, 1);
    check("R1 no switch while held", src_sel, 0);
    check("R1 no request while held", rst_req, 0);
    ref_fail = 0;
    step();
    check("R1 released", rst_hold, 0);
    step();
    check("R1 stays released", rst_hold, 0);

    // R8/R9: flag clear vs sticky
    cfg_locirq = 1; pll_fail = 1;
    step();
    pll_fail = 0;
    check("R3 pll fail to ref", src_sel, 1);
    check("R9 irq raised", irq, 1);
    step();
    check("R9 irq level held", irq, 1);
    flag_clr = 1;
    step();
    flag_clr = 0;
    check("R8 flag cleared", loc_flag, 0);
    check("R9 irq dropped", irq, 0);
    check("R8 sticky kept", loc_sticky, 1);
    check("R5 source kept", src_sel, 1);

    // sweep of configurations and failure combinations
    for (int c = 0; c < 128; c++) begin
      bit byp, en, re, iq, rf, pf, so, e1, e2, cause;
      int s0, s1, s2;
      string sc;
      byp = c[0]; en = c[1]; re = c[2]; iq = c[3];
      rf = c[4]; pf = c[5]; so = c[6];
      sc = $sformatf("c%0d", c);
      rst_n = 0; por_n = 0;
      cfg_bypass = byp; cfg_loc_en = en; cfg_locre = re; cfg_locirq = iq;
      ref_fail = 0; pll_fail = 0; scm_ok = so; pll_lock = 1;
      @(negedge clk);
      rst_n = 1; por_n = 1;
      step();
      check({"R1 release ", sc}, rst_hold, 0);
      s0 = 0;
      check_view({"idle ", sc}, s0, byp, 1'b1);
      // stage 1
      ref_fail = rf; pll_fail = pf;
      step();
      s1 = model_src(s0, byp, en, rf, pf, so);
      e1 = (s1 != s0);
      check_view({"R3 R4 R6 stage1 ", sc}, s1, byp, 1'b1);
      check({"R7 rst_req stage1 ", sc}, rst_req, (e1 && re) ? 1 : 0);
      check({"R8 loc_flag stage1 ", sc}, loc_flag, e1 ? 1 : 0);
      check({"R8 loc_sticky stage1 ", sc}, loc_sticky, e1 ? 1 : 0);
      check({"R9 irq stage1 ", sc}, irq, (e1 && iq && en && !byp) ? 1 : 0);
      // failures removed: source is sticky
      ref_fail = 0; pll_fail = 0;
      step();
      check_view({"R5 recovered ", sc}, s1, byp, 1'b1);
      check({"R7 pulse ends ", sc}, rst_req, 0);
      // stage 2: reference failure with self-clocked possible
      ref_fail = 1; scm_ok = 1;
      step();
      ref_fail = 0;
      s2 = model_src(s1, byp, en, 1'b1, 1'b0, 1'b1);
      e2 = (s2 != s1);
      check_view({"R4 stage2 ", sc}, s2, byp, 1'b1);
      check({"R7 rst_req stage2 ", sc}, rst_req, (e2 && re) ? 1 : 0);
      step();
      cause = (e1 || e2) && re;
      // system reset only: cause bit survives, flags clear
      rst_n = 0;
      @(negedge clk);
      check({"R10 cause survives ", sc}, rst_by_loc, cause ? 1 : 0);
      check({"R8 flag reset ", sc}, loc_flag, 0);
      check({"R8 sticky reset ", sc}, loc_sticky, 0);
      check({"R2 src reset ", sc}, src_sel, byp ? 1 : 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule